// File: doc/BRIEF.md
# Stack Pointer Limit Checker

This block sits at the register write-back stage of a small microcontroller-class core. It inspects every result headed for the register file. When the result is a new stack pointer value (r13) produced by one of a small set of instruction forms, it compares that value against the active stack limit. A value below the limit is a stack overflow. The write is then dropped, and a stack-overflow exception request is raised in the same cycle.

The block holds four limit registers internally: main stack and process stack, each with a secure and a non-secure copy. The current stack-select and security-state bits pick one of them. For the two stack-adjust immediate forms the block computes the new stack pointer itself from the current stack pointer and the immediate. For every other form it forwards the ALU result. A global enable turns checking off. The write-back then behaves like a plain register write.

Top module: `sp_limit_guard`

## Requirements
- R1: The active limit is one of four limit registers, chosen by the process-stack select bit and the security bit. `lim_sel` = {process, secure} addresses them: 00 main non-secure, 01 main secure, 10 process non-secure, 11 process secure. A write with `lim_we` high is used from the next cycle on.
- R2: A checked write is a violation when its new value is unsigned-less-than the active limit. A value equal to the limit is allowed.
- R3: On a violation, `wr_en` is low and `stkof_req` is high in the same cycle as `wb_valid`. Otherwise `wr_en` equals `wb_valid` and `stkof_req` is low.
- R4: Class 1 (16-bit stack adjust) writes r13 (`wr_idx` = 13). The new value is `sp_cur` plus `ins_imm[6:0]`*4, or minus that amount when `ins_imm[7]` is 1. It is always checked.
- R5: Class 2 (16-bit high-register add) and class 3 (16-bit register move) are checked only when `ins_rd` is 13. Their value is `alu_result`.
- R6: Class 4 (32-bit data processing) is checked only when `ins_rd` is 13 and one of these holds: (`ins_op`=2 with `ins_rn`=15), (`ins_op`=8 with `ins_rn`=13), or (`ins_op`=13 with `ins_rn`=13).
- R7: Class 5 (32-bit 12-bit immediate add/subtract) with `ins_rn`=13 produces `sp_cur` plus `ins_imm`, or minus it when `ins_sub`=1. It is checked only when `ins_rd` is also 13.
- R8: With `stk_chk_en` low, no write is ever suppressed and `stkof_req` stays low.
- R9: Class 0 and every write whose form is not listed above pass unchanged: `wr_en` high, `wr_data` = `alu_result`, no fault.
- R10: After reset all four limits are zero, so no value violates any limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stk_chk_en | input | 1 | Global stack-check enable |
| lim_we | input | 1 | Limit register write strobe |
| lim_sel | input | 2 | Limit register select {process, secure} |
| lim_wdata | input | DATA_W | Limit register write value |
| wb_valid | input | 1 | A write-back is presented this cycle |
| ins_class | input | 3 | Instruction form class (0..5) |
| ins_op | input | 4 | Data-processing opcode |
| ins_rd | input | 4 | Destination register index |
| ins_rn | input | 4 | First source register index |
| ins_imm | input | 12 | Immediate field |
| ins_sub | input | 1 | Subtract select for class 5 |
| sp_cur | input | DATA_W | Current stack pointer value |
| alu_result | input | DATA_W | Result computed by the ALU |
| use_psp | input | 1 | Process stack selected |
| sec_state | input | 1 | Secure state |
| wr_en | output | 1 | Register file write enable |
| wr_idx | output | 4 | Register file write index |
| wr_data | output | DATA_W | Register file write value |
| stkof_req | output | 1 | Stack-overflow exception request |

## Verification
The hardest case to reach is a value that hits one limit register exactly while lying below another. Only the stack-select and security bits then decide whether a fault fires. The stimulus first loads four distinct limits. It then replays one fixed value under all four select/security combinations, and it places stack-adjust results on the limit and one word below it. Each 32-bit form is also presented with a near-miss register or opcode, so that a decoder which is too loose shows up as a spurious fault.

// File: rtl/sp_guard_pkg.sv
package sp_guard_pkg;

   localparam logic [2:0] CLS_OTHER = 3'd0;
   localparam logic [2:0] CLS_SPADJ = 3'd1;
   localparam logic [2:0] CLS_HIADD = 3'd2;
   localparam logic [2:0] CLS_HIMOV = 3'd3;
   localparam logic [2:0] CLS_DP32  = 3'd4;
   localparam logic [2:0] CLS_IMM12 = 3'd5;

   localparam logic [3:0] REG_SP = 4'd13;
   localparam logic [3:0] REG_PC = 4'd15;

   localparam logic [3:0] DP_MOV = 4'd2;
   localparam logic [3:0] DP_ADD = 4'd8;
   localparam logic [3:0] DP_SUB = 4'd13;

   localparam int LIM_COUNT = 4;

   function automatic logic [1:0] lim_index(input logic proc, input logic sec);
      return {proc, sec};
   endfunction

endpackage

// File: rtl/sp_lim_bank.sv
module sp_lim_bank
   import sp_guard_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_proc,
   input  logic              rd_sec,
   output logic [DATA_W-1:0] lim
);

   logic [DATA_W-1:0] lim_q [LIM_COUNT];

   for (genvar g = 0; g < LIM_COUNT; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_q[g] <= '0;
         end else if (we && (wsel == 2'(g))) begin
            lim_q[g] <= wdata;
         end
      end
   end

   assign lim = lim_q[lim_index(rd_proc, rd_sec)];

   AST_LIM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (lim_q[$past(wsel)] == $past(wdata))); // R1

endmodule

// File: rtl/sp_form_decode.sv
module sp_form_decode
   import sp_guard_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        cls,
   input  logic [3:0]        op,
   input  logic [3:0]        rd,
   input  logic [3:0]        rn,
   input  logic [11:0]       imm,
   input  logic              sub,
   input  logic [DATA_W-1:0] sp_cur,
   input  logic [DATA_W-1:0] alu_result,
   output logic              need_chk,
   output logic [3:0]        dst_idx,
   output logic [DATA_W-1:0] new_val
);

   localparam int ADJ_PAD = DATA_W - 9;
   localparam int IMM_PAD = DATA_W - 12;

   logic [DATA_W-1:0] adj_off;
   logic [DATA_W-1:0] imm_off;
   logic              rd_sp;
   logic              rn_sp;
   logic              dp_hit;

   assign adj_off = {{ADJ_PAD{1'b0}}, imm[6:0], 2'b00};
   assign imm_off = {{IMM_PAD{1'b0}}, imm};
   assign rd_sp   = (rd == REG_SP);
   assign rn_sp   = (rn == REG_SP);
   assign dp_hit  = ((op == DP_MOV) && (rn == REG_PC)) ||
                    ((op == DP_ADD) && rn_sp) ||
                    ((op == DP_SUB) && rn_sp);

   always_comb begin
      need_chk = 1'b0;
      dst_idx  = rd;
      new_val  = alu_result;
      case (cls)
         CLS_SPADJ: begin
            need_chk = 1'b1;
            dst_idx  = REG_SP;
            new_val  = imm[7] ? (sp_cur - adj_off) : (sp_cur + adj_off);
         end
         CLS_HIADD, CLS_HIMOV: begin
            need_chk = rd_sp;
         end
         CLS_DP32: begin
            need_chk = rd_sp && dp_hit;
         end
         CLS_IMM12: begin
            if (rn_sp) begin
               new_val = sub ? (sp_cur - imm_off) : (sp_cur + imm_off);
            end
            need_chk = rd_sp && rn_sp;
         end
         default: begin
            need_chk = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sp_lim_compare.sv
module sp_lim_compare #(
   parameter int DATA_W     = 32,
   parameter bit USE_BORROW = 1'b1
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] limit,
   output logic              below
);

   if (USE_BORROW) begin : g_borrow
      logic [DATA_W:0] diff;
      assign diff  = {1'b0, value} - {1'b0, limit};
      assign below = diff[DATA_W];
   end else begin : g_direct
      assign below = (value < limit);
   end

endmodule

// File: rtl/sp_limit_guard.sv
module sp_limit_guard
   import sp_guard_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit USE_BORROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stk_chk_en,
   input  logic              lim_we,
   input  logic [1:0]        lim_sel,
   input  logic [DATA_W-1:0] lim_wdata,
   input  logic              wb_valid,
   input  logic [2:0]        ins_class,
   input  logic [3:0]        ins_op,
   input  logic [3:0]        ins_rd,
   input  logic [3:0]        ins_rn,
   input  logic [11:0]       ins_imm,
   input  logic              ins_sub,
   input  logic [DATA_W-1:0] sp_cur,
   input  logic [DATA_W-1:0] alu_result,
   input  logic              use_psp,
   input  logic              sec_state,
   output logic              wr_en,
   output logic [3:0]        wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              stkof_req
);

   if (DATA_W < 16 || DATA_W > 64) begin : g_bad_width
      $error("sp_limit_guard: DATA_W must lie in 16..64");
   end

   logic [DATA_W-1:0] act_lim;
   logic              need_chk;
   logic              below;
   logic              viol;

   sp_lim_bank #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (lim_we),
      .wsel    (lim_sel),
      .wdata   (lim_wdata),
      .rd_proc (use_psp),
      .rd_sec  (sec_state),
      .lim     (act_lim)
   );

   sp_form_decode #(.DATA_W(DATA_W)) u_dec (
      .cls        (ins_class),
      .op         (ins_op),
      .rd         (ins_rd),
      .rn         (ins_rn),
      .imm        (ins_imm),
      .sub        (ins_sub),
      .sp_cur     (sp_cur),
      .alu_result (alu_result),
      .need_chk   (need_chk),
      .dst_idx    (wr_idx),
      .new_val    (wr_data)
   );

   sp_lim_compare #(.DATA_W(DATA_W), .USE_BORROW(USE_BORROW)) u_cmp (
      .value (wr_data),
      .limit (act_lim),
      .below (below)
   );

   assign viol      = wb_valid && stk_chk_en && need_chk && below;
   assign stkof_req = viol;
   assign wr_en     = wb_valid && !viol;

   AST_FAULT_KILLS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      stkof_req |-> !wr_en); // R3
   AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !stkof_req) |-> wr_en); // R3
   AST_FAULT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      stkof_req |-> (wr_data < act_lim)); // R2
   AST_DISABLED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !stk_chk_en |-> !stkof_req); // R8
   AST_OTHER_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_class == CLS_OTHER) |-> !stkof_req); // R9
   AST_NON_SP_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_class != CLS_SPADJ && ins_rd != REG_SP) |-> !stkof_req); // R5
   AST_SPADJ_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && ins_class == CLS_SPADJ) |-> (wr_idx == REG_SP)); // R4

endmodule

// File: tb/test_sp_limit_guard.sv
module test_sp_limit_guard;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   typedef struct {
      logic         we;
      logic [3:0]   idx;
      logic [W-1:0] data;
      logic         fault;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stk_chk_en = 1'b1;
   logic lim_we = 1'b0;
   logic [1:0] lim_sel = '0;
   logic [W-1:0] lim_wdata = '0;
   logic wb_valid = 1'b0;
   logic [2:0] ins_class = '0;
   logic [3:0] ins_op = '0, ins_rd = '0, ins_rn = '0;
   logic [11:0] ins_imm = '0;
   logic ins_sub = 1'b0;
   logic [W-1:0] sp_cur = '0, alu_result = '0;
   logic use_psp = 1'b0, sec_state = 1'b0;
   logic wr_en, stkof_req;
   logic [3:0] wr_idx;
   logic [W-1:0] wr_data;

   exp_t q[$];
   logic [W-1:0] lim_m [4] = '{default: '0};
   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_limit_guard #(.DATA_W(W)) i_sp_limit_guard (
      .clk(clk), .rst_n(rst_n), .stk_chk_en(stk_chk_en),
      .lim_we(lim_we), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
      .wb_valid(wb_valid), .ins_class(ins_class), .ins_op(ins_op),
      .ins_rd(ins_rd), .ins_rn(ins_rn), .ins_imm(ins_imm), .ins_sub(ins_sub),
      .sp_cur(sp_cur), .alu_result(alu_result), .use_psp(use_psp),
      .sec_state(sec_state), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .stkof_req(stkof_req)
   );

   task automatic put_lim(input logic [1:0] sel, input logic [W-1:0] v);
      @(posedge clk); #1;
      wb_valid = 1'b0;
      lim_we = 1'b1; lim_sel = sel; lim_wdata = v;
      @(posedge clk); #1;
      lim_we = 1'b0;
      lim_m[sel] = v;
   endtask

   task automatic send(input logic [2:0] cls, input logic [3:0] op,
                       input logic [3:0] rd, input logic [3:0] rn,
                       input logic [11:0] imm, input logic sub,
                       input logic [W-1:0] sp, input logic [W-1:0] alu,
                       input logic psp, input logic sec, input logic en,
                       input string tag);
      exp_t e;
      logic need;
      logic [W-1:0] off;
      logic [W-1:0] lim;
      @(posedge clk); #1;
      wb_valid = 1'b1; ins_class = cls; ins_op = op; ins_rd = rd; ins_rn = rn;
      ins_imm = imm; ins_sub = sub; sp_cur = sp; alu_result = alu;
      use_psp = psp; sec_state = sec; stk_chk_en = en;
      case (cls)
         3'd1: need = 1'b1;
         3'd2, 3'd3: need = (rd == 4'd13);
         3'd4: need = (rd == 4'd13) && ((op == 4'd2 && rn == 4'd15) ||
                      (op == 4'd8 && rn == 4'd13) || (op == 4'd13 && rn == 4'd13));
         3'd5: need = (rd == 4'd13) && (rn == 4'd13);
         default: need = 1'b0;
      endcase
      e.data = alu;
      e.idx = rd;
      if (cls == 3'd1) begin
         off = W'(imm[6:0]) * 4;
         e.data = imm[7] ? sp - off : sp + off;
         e.idx = 4'd13;
      end else if (cls == 3'd5 && rn == 4'd13) begin
         e.data = sub ? sp - W'(imm) : sp + W'(imm);
      end
      lim = lim_m[{psp, sec}];
      e.fault = en && need && (e.data < lim);
      e.we = !e.fault;
      e.tag = tag;
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (wb_valid) begin
            if (q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL scoreboard: result with nothing expected");
            end else begin
               exp_t e;
               e = q.pop_front();
               n_chk++;
               if (wr_en !== e.we || stkof_req !== e.fault) begin
                  n_fail++;
                  $display("FAIL %s/R3 wr_en,stkof actual %b%b expected %b%b",
                           e.tag, wr_en, stkof_req, e.we, e.fault);
               end
               n_chk++;
               if (wr_data !== e.data || wr_idx !== e.idx) begin
                  n_fail++;
                  $display("FAIL %s data/idx actual %h/%0d expected %h/%0d",
                           e.tag, wr_data, wr_idx, e.data, e.idx);
               end
            end
         end else begin
            n_chk++;
            if (wr_en !== 1'b0 || stkof_req !== 1'b0) begin
               n_fail++;
               $display("FAIL R3 idle wr_en,stkof actual %b%b expected 00",
                        wr_en, stkof_req);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: zero limits after reset; a small value and a wrap-around pass
      send(3'd1, 4'd0, 4'd0, 4'd0, 12'h081, 1'b0, 32'h0000_0008, 32'h0, 1'b0, 1'b0, 1'b1, "R10");
      send(3'd3, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, "R10");
      send(3'd1, 4'd0, 4'd0, 4'd0, 12'h081, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, "R10");
      // R1: load four distinct limits
      put_lim(2'b00, 32'h2000_0100);
      put_lim(2'b01, 32'h3000_0000);
      put_lim(2'b10, 32'h1000_0000);
      put_lim(2'b11, 32'h4000_0000);
      // R1: one value against every select/security combination
      send(3'd3, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h2FFF_FFF0, 1'b0, 1'b0, 1'b1, "R1");
      send(3'd3, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h2FFF_FFF0, 1'b0, 1'b1, 1'b1, "R1");
      send(3'd3, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h2FFF_FFF0, 1'b1, 1'b0, 1'b1, "R1");
      send(3'd3, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h2FFF_FFF0, 1'b1, 1'b1, 1'b1, "R1");
      // R4/R2: stack adjust onto the limit, one word below, and upward
      send(3'd1, 4'd0, 4'd0, 4'd0, 12'h0C0, 1'b0, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b1, "R2");
      send(3'd1, 4'd0, 4'd0, 4'd0, 12'h0C1, 1'b0, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b1, "R4");
      send(3'd1, 4'd0, 4'd7, 4'd0, 12'h005, 1'b0, 32'h2000_0000, 32'h0, 1'b0, 1'b0, 1'b1, "R4");
      // R5: high add / move only on r13
      send(3'd2, 4'd0, 4'd13, 4'd0, 12'h0, 1'b0, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, "R5");
      send(3'd2, 4'd0, 4'd12, 4'd0, 12'h0, 1'b0, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, "R5");
      send(3'd3, 4'd0, 4'd5, 4'd0, 12'h0, 1'b0, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, "R5");
      // R6: 32-bit data-processing forms and near misses
      send(3'd4, 4'd2, 4'd13, 4'd15, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      send(3'd4, 4'd2, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      send(3'd4, 4'd8, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      send(3'd4, 4'd8, 4'd13, 4'd12, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      send(3'd4, 4'd13, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      send(3'd4, 4'd4, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R6");
      // R7: 12-bit immediate add/subtract
      send(3'd5, 4'd0, 4'd13, 4'd13, 12'h101, 1'b1, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b1, "R7");
      send(3'd5, 4'd0, 4'd13, 4'd13, 12'h101, 1'b0, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b1, "R7");
      send(3'd5, 4'd0, 4'd12, 4'd13, 12'h101, 1'b1, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b1, "R7");
      send(3'd5, 4'd0, 4'd13, 4'd4, 12'h101, 1'b1, 32'h2000_0200, 32'h0000_0040, 1'b0, 1'b0, 1'b1, "R7");
      // R8: checking disabled
      send(3'd1, 4'd0, 4'd0, 4'd0, 12'h0C1, 1'b0, 32'h2000_0200, 32'h0, 1'b0, 1'b0, 1'b0, "R8");
      send(3'd4, 4'd8, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0010, 1'b1, 1'b1, 1'b0, "R8");
      // R9: unlisted class writing r13
      send(3'd0, 4'd8, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0020, 1'b1, 1'b1, 1'b1, "R9");
      send(3'd6, 4'd8, 4'd13, 4'd13, 12'h0, 1'b0, 32'h0, 32'h0000_0020, 1'b0, 1'b1, 1'b1, "R9");
      @(posedge clk); #1;
      wb_valid = 1'b0;
      stk_chk_en = 1'b1;
      repeat (3) @(posedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R3 results missing: actual %0d pending expected 0", q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule